// File: doc/BRIEF.md
# Synchronous Clock Stop Gate

This block sits between a derived clock and a group of its copies that leave the chip, for example the copies that feed a processor or an expansion bus. It turns each copy on or off from two sources: an asynchronous active-low stop request shared by the whole group, and one enable bit per copy taken from a configuration register. The stop request is first brought into the clock domain through a chain of flops. The enable that drives each output's gate only changes on the falling edge of the source clock. An output therefore stops only during a low phase and restarts only with a complete high phase, and no shortened pulse is ever produced.

One output of the group is free-running. It ignores the stop request but still follows its own enable bit. The stop request is honoured only when the mode input selects power-management mode (mode low). After each restart the group delivers a minimum number of full cycles, even when the stop request comes back at once. Clock synthesis and pad drive belong to other blocks.

Top module: `clkstop_gate`

## Requirements
- R1: An output is never high while the source clock is low. Every high pulse on an output is a full high phase of the source clock.
- R2: The stop request level present at rising edge k of `clk_src` is acted on at the pulse of rising edge k+SYNC_STAGES (default 2). With `pm_sel_n` low and `stop_req_n` low, that pulse and later pulses are absent on every gated output.
- R3: After `stop_req_n` returns high, gated outputs resume with the same latency as R2, and the first pulse is a full high phase.
- R4: Output index FREE_IDX (default 0) pulses whenever its enable bit is 1, whatever the level of `stop_req_n`.
- R5: An output whose bit in `out_en` is 0 is held low. A bit value present at a falling edge controls the pulse of the next rising edge.
- R6: With `pm_sel_n` high, the stop request has no effect and all enabled outputs keep pulsing.
- R7: While `rst_n` is low (synchronous, active low), all outputs are held low.
- R8: Once the group restarts, it delivers at least MIN_RUN (default 3) consecutive pulses before a new stop can take effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_src | input | 1 | Source clock to be gated |
| rst_n | input | 1 | Synchronous active-low reset |
| stop_req_n | input | 1 | Asynchronous active-low group stop request |
| pm_sel_n | input | 1 | Mode select: 0 means power-management mode, where stops are honoured |
| out_en | input | N_OUT | Per-output enable bits from the configuration register; 1 means enabled |
| clk_out | output | N_OUT | Gated clock outputs |

## Verification
An enable bit or mode level driven in the high phase after rising edge k takes effect at the pulse of rising edge k+1. A stop level driven at the same point takes effect at edge k+3, because it must first pass the two synchronizer flops. The bench keeps a three-deep history of its own stimulus. It computes each expected pulse from the entries that match those delays and applies the minimum-run rule as a consecutive-pulse count. Each output is sampled in the middle of the high phase against that expectation, and in the middle of the low phase, where every output must be low.

// File: rtl/clkstop_pkg.sv
// Shared helpers for the clock stop gate.
// Assumes: parameters are small positive integers.
package clkstop_pkg;

    // Counter width able to hold values 0..limit.
    function automatic int unsigned cnt_bits(input int unsigned limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/clkstop_sync.sv
// Brings the asynchronous active-low stop request into the clk domain.
// Assumes: the request is a level held for more than STAGES cycles; the
// synchronizer resets to the idle (not stopped) level.
module clkstop_sync
    import clkstop_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_n,
    output logic sync_n
);
    localparam int unsigned AW = cnt_bits(STAGES);

    logic [STAGES-1:0] chain_q;
    logic [AW-1:0]     age_q;

    // Shift the request through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], async_n};
    end

    // Count cycles since reset, saturating, so the delay check sees only valid history.
    always_ff @(posedge clk) begin
        if (!rst_n)                    age_q <= '0;
        else if (age_q != AW'(STAGES)) age_q <= age_q + 1'b1;
    end

    assign sync_n = chain_q[STAGES-1];

    AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == AW'(STAGES)) |-> (sync_n == $past(async_n, STAGES))); // R2

endmodule

// File: rtl/clkstop_ctrl.sv
// Decides whether the gated part of the group runs in the next clock cycle.
// Applies the mode qualifier and holds the group running for MIN_RUN cycles
// after each restart.
// Assumes: stop_n is already synchronous to clk; pm_sel_n is quasi-static.
module clkstop_ctrl
    import clkstop_pkg::*;
#(
    parameter int unsigned MIN_RUN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stop_n,
    input  logic pm_sel_n,
    output logic grp_run
);
    localparam int unsigned CW = cnt_bits(MIN_RUN);

    logic          stop_eff;
    logic          run_prev_q;
    logic [CW-1:0] hold_q;

    // A stop counts only in power-management mode; the hold counter overrides it.
    always_comb begin
        stop_eff = ~stop_n & ~pm_sel_n;
        grp_run  = ~stop_eff | (hold_q != '0);
    end

    // Load the minimum-run window on a restart and count it down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_prev_q <= 1'b0;
            hold_q     <= '0;
        end else begin
            run_prev_q <= grp_run;
            if (grp_run && !run_prev_q) hold_q <= CW'(MIN_RUN - 1);
            else if (hold_q != '0)      hold_q <= hold_q - 1'b1;
        end
    end

    AST_MIN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_run && !run_prev_q && (MIN_RUN > 1)) |=> grp_run); // R8
    AST_MODE_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        pm_sel_n |-> grp_run); // R6
    AST_STAY_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (!stop_n && !$past(stop_n) && !pm_sel_n && !$past(pm_sel_n) && !$past(grp_run))
        |-> !grp_run); // R2

endmodule

// File: rtl/clkstop_cell.sv
// One output gate: the enable is captured on the falling edge, so it only
// changes while the clock is low, and the output is clock AND enable.
// Assumes: allow is stable around the falling edge of clk.
module clkstop_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic allow,
    output logic en_q,
    output logic gclk
);
    // Capture the enable in the low phase.
    always_ff @(negedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= allow;
    end

    assign gclk = clk & en_q;

endmodule

// File: rtl/clkstop_gate.sv
// Top level: clock stop gate for a group of N_OUT copies of clk_src.
// Output FREE_IDX is exempt from the group stop request.
// Assumes: out_en and pm_sel_n change in the high phase of clk_src.
module clkstop_gate
    import clkstop_pkg::*;
#(
    parameter int unsigned N_OUT       = 7,
    parameter int unsigned FREE_IDX    = 0,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned MIN_RUN     = 3
) (
    input  logic             clk_src,
    input  logic             rst_n,
    input  logic             stop_req_n,
    input  logic             pm_sel_n,
    input  logic [N_OUT-1:0] out_en,
    output logic [N_OUT-1:0] clk_out
);
    logic             stop_sync_n;
    logic             grp_run;
    logic [N_OUT-1:0] gate_en;

    clkstop_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk_src),
        .rst_n   (rst_n),
        .async_n (stop_req_n),
        .sync_n  (stop_sync_n)
    );

    clkstop_ctrl #(.MIN_RUN(MIN_RUN)) u_ctrl (
        .clk      (clk_src),
        .rst_n    (rst_n),
        .stop_n   (stop_sync_n),
        .pm_sel_n (pm_sel_n),
        .grp_run  (grp_run)
    );

    for (genvar i = 0; i < N_OUT; i++) begin : g_out
        logic allow;
        if (i == FREE_IDX) begin : g_free
            // The free-running output follows only its enable bit.
            always_comb allow = out_en[i];
            AST_FREE_RUNS: assert property (@(negedge clk_src) disable iff (!rst_n)
                out_en[i] |=> gate_en[i]); // R4
        end else begin : g_stop
            // A gated output needs both its enable bit and a running group.
            always_comb allow = out_en[i] & grp_run;
        end

        clkstop_cell u_cell (
            .clk   (clk_src),
            .rst_n (rst_n),
            .allow (allow),
            .en_q  (gate_en[i]),
            .gclk  (clk_out[i])
        );

        AST_EN_OFF_LOW: assert property (@(negedge clk_src) disable iff (!rst_n)
            !out_en[i] |=> !gate_en[i]); // R5
    end

endmodule

// File: tb/clkstop_gate_bench.sv
`timescale 1ns/1ps
module clkstop_gate_bench;
    localparam int N      = 7;
    localparam int FREE   = 0;
    localparam int MINRUN = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         stop_req_n = 1'b1;
    logic         pm_sel_n = 1'b0;
    logic [N-1:0] out_en = '1;
    logic [N-1:0] clk_out;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // Stimulus history and reference state.
    logic         s_d1 = 1'b1, s_d2 = 1'b1, s_d3 = 1'b1;
    logic         m_d1 = 1'b0, r_d1 = 1'b0;
    logic [N-1:0] e_d1 = '1;
    logic         prev_run = 1'b1;
    int           run_cnt = MINRUN;

    always #2.5 clk = ~clk;

    clkstop_gate #(.N_OUT(N), .FREE_IDX(FREE), .SYNC_STAGES(2), .MIN_RUN(MINRUN)) u_clkstop_gate (
        .clk_src(clk), .rst_n(rst_n), .stop_req_n(stop_req_n),
        .pm_sel_n(pm_sel_n), .out_en(out_en), .clk_out(clk_out)
    );

    // Group run decision from the requirements: stop seen 3 edges later, mode and enable 1 edge later.
    function automatic logic ref_run(input logic s3, input logic m1, input logic pr, input int rc);
        return !(!s3 && !m1) || (pr && rc < MINRUN);
    endfunction

    function automatic string tag_of(input int i, input logic rst1, input logic en1,
                                     input logic m1, input logic s3, input logic run);
        if (!rst1)     return "R7";
        if (i == FREE) return "R4";
        if (!en1)      return "R5";
        if (m1)        return "R6";
        if (!s3 && run) return "R8";
        if (run)       return "R3";
        return "R2";
    endfunction

    task automatic step(input logic s, input logic m, input logic [N-1:0] e, input logic r);
        logic         run;
        logic [N-1:0] exp;
        @(posedge clk);
        cyc++;
        run = ref_run(s_d3, m_d1, prev_run, run_cnt);
        if (!r_d1) begin
            prev_run = 1'b1;
            run_cnt  = MINRUN;
            exp      = '0;
        end else begin
            run_cnt  = run ? (prev_run ? run_cnt + 1 : 1) : 0;
            prev_run = run;
            exp      = run ? e_d1 : (e_d1 & (N'(1) << FREE));
        end
        #1.0;
        stop_req_n = s; pm_sel_n = m; out_en = e; rst_n = r;
        #0.25;
        if (cyc >= 2) begin
            for (int i = 0; i < N; i++) begin
                checks++;
                if (clk_out[i] !== exp[i]) begin
                    errors++;
                    $display("FAIL %s cycle %0d out[%0d] high phase: actual=%b expected=%b",
                             tag_of(i, r_d1, e_d1[i], m_d1, s_d3, run), cyc, i, clk_out[i], exp[i]);
                end
            end
        end
        #2.5;
        if (cyc >= 2) begin
            checks++;
            if (clk_out !== '0) begin
                errors++;
                $display("FAIL R1 cycle %0d low phase: actual=%b expected=%b", cyc, clk_out, {N{1'b0}});
            end
        end
        s_d3 = s_d2; s_d2 = s_d1; s_d1 = s;
        m_d1 = m; e_d1 = e; r_d1 = r;
    endtask

    task automatic hold(input logic s, input logic m, input logic [N-1:0] e, input int n);
        for (int k = 0; k < n; k++) step(s, m, e, 1'b1);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        logic         s, m;
        logic [N-1:0] e;
        void'($urandom(32'd20240917));
        for (int k = 0; k < 5; k++) step(1'b1, 1'b0, '1, 1'b0);   // R7 reset
        hold(1'b1, 1'b0, '1, 12);                                  // normal run
        hold(1'b0, 1'b0, '1, 20);                                  // R2 stop, R4 free output
        hold(1'b1, 1'b0, '1, 1);                                   // R8 short release
        hold(1'b0, 1'b0, '1, 15);
        hold(1'b1, 1'b0, '1, 15);                                  // R3 restart
        hold(1'b0, 1'b1, '1, 15);                                  // R6 stop ignored
        hold(1'b0, 1'b0, '1, 10);
        hold(1'b1, 1'b0, 7'b1010100, 10);                          // R5 disabled outputs
        hold(1'b0, 1'b0, 7'b0101010, 10);                          // R4 free output disabled
        s = 1'b1; m = 1'b0; e = '1;
        for (int seg = 0; seg < 250; seg++) begin
            s = $urandom % 2;
            if ($urandom % 8 == 0) m = ~m;
            if ($urandom % 4 == 0) e = N'($urandom);
            hold(s, m, e, 1 + ($urandom % 12));
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule